// File: doc/BRIEF.md
# Cascaded Vectored Interrupt Controller

The block gathers 32 main interrupt lines and 11 sub-source lines and turns them into one request to the CPU. Each main line is captured into a source-pending register. Sub-sources are captured into a separate sub-pending register. Each sub-source can be gated by its own sub-mask bit, and the sub-sources are merged in groups onto shared main lines.

The controller holds a single interrupt-pending bit at a time. When no interrupt-pending bit is set, the controller takes the lowest-indexed source that is pending and whose mask bit is clear, and sets its interrupt-pending bit. The index of that bit can be read from an offset register, and the CPU request is high while the bit is set.

Software services an interrupt in three steps: it reads the offset, clears the source-pending bit, then clears the interrupt-pending bit. All registers are reached through a simple register bus. Writes take effect at the clock edge, and reads are combinational from the address.

Top module: `casc_irq_ctrl`

## Requirements
- R1: At most one bit of the interrupt-pending register (address 2) is set at any time.
- R2: The offset register (address 3) reads the bit index of the set interrupt-pending bit, and reads 0 when none is set.
- R3: Source-pending bit k (address 0) is set by a rising edge of `src_i[k]` and stays set until a write of 1 to bit k. Writing 0 has no effect. A set and a clear in the same cycle leave the bit set.
- R4: Interrupt-pending bits are cleared by writing 1 to them. A new bit is loaded only in a cycle that starts with no interrupt-pending bit set. It is chosen from source-pending bits whose mask bit (address 1) is 0, and it appears one cycle after the source-pending bit. A masked source never loads.
- R5: When several eligible sources are pending, the lowest index is loaded.
- R6: `irq_o` is high exactly when an interrupt-pending bit is set.
- R7: Sub-sources 0-2 feed main line 28, sub-sources 3-5 feed main line 23, sub-sources 6-8 feed main line 15, and sub-sources 9-10 feed main line 31. An active group sets its main source-pending bit in every cycle it is active, one cycle after the sub-pending or sub-mask change.
- R8: A sub-source drives its group only while its sub-pending bit is 1 and its sub-mask bit is 0.
- R9: Sub-pending bit j (address 4, bits 10:0) is set by a rising edge of `sub_i[j]` and cleared by writing 1 to bit j. A set wins over a clear in the same cycle.
- R10: After reset, source-pending, interrupt-pending, sub-pending and offset read 0. The mask reads 0xFFFFFFFF, the sub-mask reads 0x7FF, and `irq_o` is 0.
- R11: The mask (address 1, 32 bits) and sub-mask (address 5, 11 bits) read back the last value written. Unused addresses and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Main interrupt lines, rising-edge captured |
| sub_i | input | 11 | Sub-source lines, rising-edge captured |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Request to the CPU |

## Verification
The assertions take `src_i`, `sub_i` and the bus inputs to be stable across each rising clock edge and free of X once reset is released. They also take every write to address 2 as carrying only bits that software means to clear. The stimulus changes every input on the falling edge. It toggles lines from seeded random draws, and when it services an interrupt it clears the source-pending bit before the interrupt-pending bit. Directed steps add the cases that random traffic rarely reaches: simultaneous edges, masked sources, zero-valued clear writes, and the sub-source path being opened by a sub-mask write.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_SRCP    = 3'd0,
    A_MASK    = 3'd1,
    A_INTP    = 3'd2,
    A_OFFS    = 3'd3,
    A_SUBP    = 3'd4,
    A_SUBMASK = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/cirq_pend.sv
// Pending register: rising-edge and level set, write-one clear, set wins.
module cirq_pend #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] edge_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] set_w;

  assign set_w  = (edge_i & ~edge_q) | lvl_i;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      pend_q <= '0;
    end else begin
      edge_q <= edge_i;
      pend_q <= (pend_q & ~clr_i) | set_w;
    end
  end

  // R3 R9
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0));
endmodule

// File: rtl/cirq_sub_merge.sv
// Merges gated sub-sources into per-main-line level requests.
module cirq_sub_merge #(
  parameter int unsigned N_SUB    = 11,
  parameter int unsigned N_MAIN   = 32,
  parameter int unsigned N_GRP    = 4,
  parameter int unsigned GRP_SIZE = 3,
  parameter int unsigned GRP_MAIN [N_GRP] = '{28, 23, 15, 31}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SUB-1:0]  subp_i,
  input  logic [N_SUB-1:0]  submask_i,
  output logic [N_MAIN-1:0] main_lvl_o
);
  logic [N_SUB-1:0] act_w;
  logic [N_GRP-1:0] grp_line;

  function automatic int unsigned grp_of(input int unsigned s);
    int unsigned g;
    g = s / GRP_SIZE;
    if (g >= N_GRP) g = N_GRP - 1;
    return g;
  endfunction

  assign act_w = subp_i & ~submask_i;

  always_comb begin
    grp_line = '0;
    for (int unsigned s = 0; s < N_SUB; s++) begin
      if (act_w[s]) grp_line[grp_of(s)] = 1'b1;
    end
  end

  always_comb begin
    main_lvl_o = '0;
    for (int unsigned k = 0; k < N_MAIN; k++) begin
      for (int unsigned g = 0; g < N_GRP; g++) begin
        if (GRP_MAIN[g] == k && grp_line[g]) main_lvl_o[k] = 1'b1;
      end
    end
  end

  // R8
  sub_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((subp_i & ~submask_i) == '0) |-> (main_lvl_o == '0));
endmodule

// File: rtl/cirq_pick.sv
// Lowest-index pick: one-hot and encoded index.
module cirq_pick #(
  parameter int unsigned W  = 32,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic [W-1:0]  oh_o,
  output logic [IW-1:0] idx_o
);
  assign oh_o = req_i & (~req_i + 1'b1);

  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = i[IW-1:0];
    end
  end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import cirq_pkg::*;
#(
  parameter int unsigned N_MAIN   = 32,
  parameter int unsigned N_SUB    = 11,
  parameter int unsigned N_GRP    = 4,
  parameter int unsigned GRP_SIZE = 3,
  parameter int unsigned GRP_MAIN [N_GRP] = '{28, 23, 15, 31},
  localparam int unsigned DATA_W  = N_MAIN,
  localparam int unsigned IDX_W   = $clog2(N_MAIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_MAIN-1:0] src_i,
  input  logic [N_SUB-1:0]  sub_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [N_MAIN-1:0] srcp, mask_q, intp_q, elig, pick_oh, main_lvl;
  logic [N_MAIN-1:0] clr_srcp, clr_intp;
  logic [N_SUB-1:0]  subp, submask_q, clr_subp;
  logic [IDX_W-1:0]  pick_idx, offs_idx;
  logic [N_MAIN-1:0] offs_oh;

  assign clr_srcp = (bus_we_i && bus_addr_i == A_SRCP) ? bus_wdata_i : '0;
  assign clr_intp = (bus_we_i && bus_addr_i == A_INTP) ? bus_wdata_i : '0;
  assign clr_subp = (bus_we_i && bus_addr_i == A_SUBP) ? bus_wdata_i[N_SUB-1:0] : '0;

  cirq_pend #(.W(N_SUB)) i_sub_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (sub_i),
    .lvl_i  ('0),
    .clr_i  (clr_subp),
    .pend_o (subp)
  );

  cirq_sub_merge #(
    .N_SUB   (N_SUB),
    .N_MAIN  (N_MAIN),
    .N_GRP   (N_GRP),
    .GRP_SIZE(GRP_SIZE),
    .GRP_MAIN(GRP_MAIN)
  ) i_merge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .subp_i    (subp),
    .submask_i (submask_q),
    .main_lvl_o(main_lvl)
  );

  cirq_pend #(.W(N_MAIN)) i_src_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (src_i),
    .lvl_i  (main_lvl),
    .clr_i  (clr_srcp),
    .pend_o (srcp)
  );

  assign elig = srcp & ~mask_q;

  cirq_pick #(.W(N_MAIN)) i_pick (
    .req_i(elig),
    .oh_o (pick_oh),
    .idx_o(pick_idx)
  );

  cirq_pick #(.W(N_MAIN)) i_offs (
    .req_i(intp_q),
    .oh_o (offs_oh),
    .idx_o(offs_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '1;
      submask_q <= '1;
      intp_q    <= '0;
    end else begin
      if (bus_we_i && bus_addr_i == A_MASK)    mask_q    <= bus_wdata_i;
      if (bus_we_i && bus_addr_i == A_SUBMASK) submask_q <= bus_wdata_i[N_SUB-1:0];
      if (intp_q == '0) intp_q <= pick_oh;
      else              intp_q <= intp_q & ~clr_intp;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_SRCP:    bus_rdata_o = srcp;
      A_MASK:    bus_rdata_o = mask_q;
      A_INTP:    bus_rdata_o = intp_q;
      A_OFFS:    bus_rdata_o = {{(DATA_W-IDX_W){1'b0}}, offs_idx};
      A_SUBP:    bus_rdata_o = {{(DATA_W-N_SUB){1'b0}}, subp};
      A_SUBMASK: bus_rdata_o = {{(DATA_W-N_SUB){1'b0}}, submask_q};
      default:   bus_rdata_o = '0;
    endcase
  end

  assign irq_o = |intp_q;

  // R1
  intp_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(intp_q));

  // R2
  offs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intp_q != '0) |-> intp_q[offs_idx]);

  // R4
  intp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intp_q != '0) |=> (intp_q == ($past(intp_q) & ~$past(clr_intp))));

  // R4
  intp_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(intp_q) == '0 && intp_q != '0) |-> ((intp_q & $past(elig)) != '0));

  // R5
  intp_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(intp_q) == '0 && intp_q != '0) |-> (($past(elig) & (intp_q - 1'b1)) == '0));
endmodule

// File: tb/test_casc_irq_ctrl.sv
module test_casc_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [10:0] sub = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_srcp, m_mask, m_intp, m_src_q;
  logic [10:0] m_subp, m_submask, m_sub_q;

  always #10 clk = ~clk;

  casc_irq_ctrl i_casc_irq_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .src_i      (src),
    .sub_i      (sub),
    .bus_we_i   (we),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .irq_o      (irq)
  );

  function automatic logic [31:0] grp_lvl(input logic [10:0] sp, input logic [10:0] sm);
    logic [10:0] a;
    logic [31:0] l;
    a = sp & ~sm;
    l = '0;
    if (|a[2:0])  l[28] = 1'b1;
    if (|a[5:3])  l[23] = 1'b1;
    if (|a[8:6])  l[15] = 1'b1;
    if (|a[10:9]) l[31] = 1'b1;
    return l;
  endfunction

  function automatic logic [31:0] low_oh(input logic [31:0] x);
    return x & (~x + 32'd1);
  endfunction

  function automatic logic [31:0] idx_of(input logic [31:0] x);
    for (int i = 0; i < 32; i++) if (x[i]) return i;
    return 0;
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_srcp <= '0; m_mask <= '1; m_intp <= '0; m_src_q <= '0;
      m_subp <= '0; m_submask <= 11'h7FF; m_sub_q <= '0;
    end else begin
      m_src_q <= src;
      m_sub_q <= sub;
      m_srcp <= (m_srcp & ~((we && addr == 3'd0) ? wdata : 32'd0))
                | (src & ~m_src_q) | grp_lvl(m_subp, m_submask);
      m_subp <= (m_subp & ~((we && addr == 3'd4) ? wdata[10:0] : 11'd0)) | (sub & ~m_sub_q);
      if (we && addr == 3'd1) m_mask <= wdata;
      if (we && addr == 3'd5) m_submask <= wdata[10:0];
      if (m_intp == '0) m_intp <= low_oh(m_srcp & ~m_mask);
      else m_intp <= m_intp & ~((we && addr == 3'd2) ? wdata : 32'd0);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic check_all();
    logic [31:0] d;
    rd(3'd0, d); chk("R3 srcp", d, m_srcp);
    rd(3'd1, d); chk("R11 mask", d, m_mask);
    rd(3'd2, d); chk("R4 intp", d, m_intp);
    rd(3'd3, d); chk("R2 offs", d, idx_of(m_intp));
    rd(3'd4, d); chk("R9 subp", d, {21'd0, m_subp});
    rd(3'd5, d); chk("R11 submask", d, {21'd0, m_submask});
    chk("R6 irq", {31'd0, irq}, {31'd0, m_intp != 0});
    chk("R1 onehot", {31'd0, $onehot0(m_intp) ? 1'b1 : 1'b0}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] cap;
    void'($urandom(32'd4711));
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R10 reset state
    rd(3'd0, d); chk("R10 srcp", d, 32'h0);
    rd(3'd1, d); chk("R10 mask", d, 32'hFFFF_FFFF);
    rd(3'd2, d); chk("R10 intp", d, 32'h0);
    rd(3'd3, d); chk("R10 offs", d, 32'h0);
    rd(3'd4, d); chk("R10 subp", d, 32'h0);
    rd(3'd5, d); chk("R10 submask", d, 32'h7FF);
    chk("R10 irq", {31'd0, irq}, 32'd0);
    rd(3'd7, d); chk("R11 unused addr", d, 32'h0);

    // R5 simultaneous edges: lowest index wins
    wr(3'd1, 32'h0);
    src = 32'h28;
    idle(2);
    rd(3'd3, d); chk("R5 offs", d, 32'd3);
    rd(3'd2, d); chk("R1 intp", d, 32'h8);
    chk("R6 irq high", {31'd0, irq}, 32'd1);
    check_all();

    // R3 write of zero leaves pending bits
    wr(3'd0, 32'h0);
    rd(3'd0, d); chk("R3 zero write", d, 32'h28);

    // R4 service bit 3, next source loads
    wr(3'd0, 32'h8);
    wr(3'd2, 32'h8);
    idle(1);
    rd(3'd3, d); chk("R4 reload offs", d, 32'd5);
    rd(3'd0, d); chk("R3 after clear", d, 32'h20);
    wr(3'd0, 32'h20);
    wr(3'd2, 32'h20);
    idle(1);
    check_all();

    // R4 masked source does not load
    wr(3'd1, 32'h80);
    src = 32'hA8;
    idle(2);
    rd(3'd0, d); chk("R4 masked pend", d, 32'h80);
    rd(3'd2, d); chk("R4 masked no load", d, 32'h0);
    chk("R6 irq low", {31'd0, irq}, 32'd0);

    // R8 / R7 sub path
    sub = 11'h002;
    idle(2);
    rd(3'd4, d); chk("R9 subp set", d, 32'h2);
    rd(3'd0, d); chk("R8 gated sub", d, 32'h80);
    wr(3'd5, 32'h7FD);
    idle(1);
    rd(3'd0, d); chk("R7 group line", d, 32'h1000_0080);
    idle(1);
    rd(3'd3, d); chk("R7 offs", d, 32'd28);
    wr(3'd4, 32'h2);
    wr(3'd0, 32'h1000_0000);
    rd(3'd0, d); chk("R7 level gone", d, 32'h80);
    wr(3'd2, 32'h1000_0000);
    idle(1);
    check_all();

    // random traffic
    for (int it = 0; it < 3000; it++) begin
      int sel;
      src = src ^ ($urandom & $urandom & $urandom & $urandom);
      sub = sub ^ 11'($urandom & $urandom & $urandom);
      sel = $urandom % 16;
      if (m_intp != 0 && sel < 6) begin
        cap = m_intp;
        wr(3'd0, cap);
        wr(3'd2, cap);
      end else if (sel == 6) begin
        wr(3'd1, $urandom & $urandom & $urandom);
      end else if (sel == 7) begin
        wr(3'd5, $urandom & $urandom);
      end else if (sel == 8) begin
        wr(3'd4, $urandom);
      end else if (sel == 9) begin
        wr(3'd0, $urandom & $urandom);
      end else begin
        idle(1);
      end
      check_all();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule